// File: doc/BRIEF.md
# Adaptive Binary Decision Decoder

This block decodes one binary decision per request from an arithmetic-coded bitstream. The probability model for each decision comes from an adaptive context. The block keeps a bank of context bytes, a 9-bit range register and a 9-bit offset register. A client presents a context index. The block returns the decoded bin, writes the adapted probability state back to that context, and then renormalises by pulling fresh compressed bits from a serial bit-input handshake.

Before decoding starts, contexts are loaded through a byte write port. The three probability tables are held on chip and are filled through a table write port: the sub-range table for the less probable symbol, and the next-state tables for both outcomes. Initialising contexts from slice parameters is left to the surrounding logic. So are equiprobable decoding, end-of-slice decoding and the mapping of bins to syntax elements.

Top module: `cabac_bin_decoder`

## Requirements
- R1: After reset the range is 510, and the offset is filled MSB-first with the first 9 bits taken through the bit handshake. `req_ready` and `rsp_valid` stay low until those 9 bits have been taken.
- R2: A context byte holds the state index in bits [5:0] and the most probable symbol (MPS) in bit 7. Bit 6 has no effect on decoding and is written back as 0.
- R3: The less-probable sub-range is read from a 64x4 table at index {state, range[7:6]}. Table select 0 writes that table, with `tbl_wr_addr` = state*4 + quarter.
- R4: The range is first reduced by the sub-range. If the offset is below the reduced range, the bin equals the MPS, the range becomes the reduced range and the offset is unchanged.
- R5: Otherwise the bin is the inverse of the MPS. The offset drops by the reduced range and the range becomes the sub-range.
- R6: The next state comes from the MPS-outcome table (select 1) when the bin equals the MPS, and from the LPS-outcome table (select 2) otherwise. Both tables are addressed by `tbl_wr_addr[5:0]`. Select 3 writes nothing.
- R7: When the bin is not the MPS and the state index is 0, the stored MPS bit is inverted in the byte written back.
- R8: While the range is below 256, each accepted bit doubles the range and shifts into the offset LSB. `req_ready` rises only once the range is at least 256, and exactly the bits needed are taken.
- R9: A request accepted at clock edge k produces a one-cycle `rsp_valid` pulse, carrying the bin, that is visible after edge k+1.
- R10: If a port write hits the same entry as the decoder's write-back in the same cycle, the port write is lost. Writes to different entries both take effect. A request reads the context value as it stood before any write in its acceptance cycle.
- R11: When `bit_valid` is low, renormalisation and initial loading hold without taking a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctx_wr_en | input | 1 | Context byte write strobe |
| ctx_wr_addr | input | 10 | Context entry to write |
| ctx_wr_data | input | 8 | Context byte {MPS, reserved, state} |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_sel | input | 2 | 0 sub-range, 1 MPS next state, 2 LPS next state |
| tbl_wr_addr | input | 8 | Table entry address |
| tbl_wr_data | input | 8 | Table entry value |
| req_valid | input | 1 | Decode request present |
| req_ready | output | 1 | Decoder can take a request |
| req_ctx | input | 10 | Context index of the request |
| rsp_valid | output | 1 | Decoded bin valid (one cycle) |
| rsp_bin | output | 1 | Decoded bin |
| bit_valid | input | 1 | Bitstream bit present |
| bit_ready | output | 1 | Decoder takes a bit this cycle |
| bit_data | input | 1 | Bitstream bit |

## Verification
Two writes can land on the context store in the same cycle: the external port write and the decoder's adapted-state write-back. The bench provokes this by writing to the context being decoded in the cycle after acceptance. It also writes to the requested context in the acceptance cycle itself, and writes to unrelated entries during decoding. A behavioural model predicts that the write-back wins on the same entry, and that the request sees the pre-write byte. Every later bin from that context is compared against this prediction, as are `req_ready` and `rsp_valid` on every clock while bit input stalls at random.

// File: rtl/cabac_pkg.sv
package cabac_pkg;
   localparam int CTX_BYTE_W = 8;

   typedef enum logic [1:0] {
      ST_INIT   = 2'd0,
      ST_IDLE   = 2'd1,
      ST_CALC   = 2'd2,
      ST_RENORM = 2'd3
   } dec_state_e;

   localparam logic [1:0] TBL_SUBRANGE = 2'd0;
   localparam logic [1:0] TBL_NEXT_MPS = 2'd1;
   localparam logic [1:0] TBL_NEXT_LPS = 2'd2;
endpackage

// File: rtl/cabac_ctx_bank.sv
module cabac_ctx_bank #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wb_en,
   input  logic [ADDR_W-1:0] wb_addr,
   input  logic [DATA_W-1:0] wb_data,
   input  logic              ext_en,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic [DATA_W-1:0] ext_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // later assignment wins: write-back overrides the port on a shared entry
   always_ff @(posedge clk) begin
      if (ext_en) mem[ext_addr] <= ext_data;
      if (wb_en)  mem[wb_addr]  <= wb_data;
      if (rd_en)  rd_data       <= mem[rd_addr];
   end

   // R10
   wb_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && ext_en && wb_addr == ext_addr) |=> mem[$past(wb_addr)] == $past(wb_data));
endmodule

// File: rtl/cabac_prob_tables.sv
module cabac_prob_tables
   import cabac_pkg::*;
#(
   parameter int STATE_W = 6,
   parameter int LPS_W   = 8
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [STATE_W+1:0] wr_addr,
   input  logic [LPS_W-1:0]   wr_data,
   input  logic [STATE_W-1:0] st_i,
   input  logic [1:0]         quart_i,
   output logic [LPS_W-1:0]   sub_o,
   output logic [STATE_W-1:0] nxt_mps_o,
   output logic [STATE_W-1:0] nxt_lps_o
);
   localparam int N_ST  = 1 << STATE_W;
   localparam int N_SUB = N_ST * 4;

   if (LPS_W < STATE_W) begin : g_bad_w
      $error("table word narrower than a state index");
   end

   logic [LPS_W-1:0]   sub_mem [N_SUB];
   logic [STATE_W-1:0] mps_mem [N_ST];
   logic [STATE_W-1:0] lps_mem [N_ST];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         unique case (wr_sel)
            TBL_SUBRANGE: sub_mem[wr_addr] <= wr_data;
            TBL_NEXT_MPS: mps_mem[wr_addr[STATE_W-1:0]] <= wr_data[STATE_W-1:0];
            TBL_NEXT_LPS: lps_mem[wr_addr[STATE_W-1:0]] <= wr_data[STATE_W-1:0];
            default: ;
         endcase
      end
   end

   assign sub_o     = sub_mem[{st_i, quart_i}];
   assign nxt_mps_o = mps_mem[st_i];
   assign nxt_lps_o = lps_mem[st_i];
endmodule

// File: rtl/cabac_bin_decoder.sv
module cabac_bin_decoder
   import cabac_pkg::*;
#(
   parameter int CTX_AW  = 10,
   parameter int STATE_W = 6,
   parameter int RANGE_W = 9,
   parameter int LPS_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctx_wr_en,
   input  logic [CTX_AW-1:0]  ctx_wr_addr,
   input  logic [7:0]         ctx_wr_data,
   input  logic               tbl_wr_en,
   input  logic [1:0]         tbl_wr_sel,
   input  logic [STATE_W+1:0] tbl_wr_addr,
   input  logic [LPS_W-1:0]   tbl_wr_data,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [CTX_AW-1:0]  req_ctx,
   output logic               rsp_valid,
   output logic               rsp_bin,
   input  logic               bit_valid,
   output logic               bit_ready,
   input  logic               bit_data
);
   localparam int CNT_W = $clog2(RANGE_W + 1);
   localparam logic [RANGE_W-1:0] RANGE_RST = RANGE_W'((1 << RANGE_W) - 2);
   localparam logic [CNT_W-1:0]   LAST_INIT = CNT_W'(RANGE_W - 1);
   localparam int PAD_W = CTX_BYTE_W - 1 - STATE_W;

   if (STATE_W > 6 || STATE_W < 1) begin : g_bad_state
      $error("state index must fit below the reserved bit");
   end
   if (RANGE_W != LPS_W + 1) begin : g_bad_range
      $error("range must be one bit wider than the sub-range");
   end

   dec_state_e st_q;
   logic [RANGE_W-1:0] range_q, off_q;
   logic [CNT_W-1:0]   init_cnt_q;
   logic [CTX_AW-1:0]  idx_q;
   logic [CTX_BYTE_W-1:0] ctx_rd, ctx_wb;

   logic [STATE_W-1:0] cur_st, nxt_mps_st, nxt_lps_st, nxt_st;
   logic               cur_mps, take_lps, nxt_mps, dec_bin, accept;
   logic [1:0]         quart;
   logic [LPS_W-1:0]   sub_rng;
   logic [RANGE_W-1:0] rng_mps, rng_nxt, off_nxt;

   assign req_ready = (st_q == ST_IDLE);
   assign bit_ready = (st_q == ST_INIT) || (st_q == ST_RENORM);
   assign accept    = req_valid && req_ready;

   cabac_ctx_bank #(.ADDR_W(CTX_AW), .DATA_W(CTX_BYTE_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (accept),
      .rd_addr  (req_ctx),
      .rd_data  (ctx_rd),
      .wb_en    (st_q == ST_CALC),
      .wb_addr  (idx_q),
      .wb_data  (ctx_wb),
      .ext_en   (ctx_wr_en),
      .ext_addr (ctx_wr_addr),
      .ext_data (ctx_wr_data)
   );

   cabac_prob_tables #(.STATE_W(STATE_W), .LPS_W(LPS_W)) u_tables (
      .clk       (clk),
      .wr_en     (tbl_wr_en),
      .wr_sel    (tbl_wr_sel),
      .wr_addr   (tbl_wr_addr),
      .wr_data   (tbl_wr_data),
      .st_i      (cur_st),
      .quart_i   (quart),
      .sub_o     (sub_rng),
      .nxt_mps_o (nxt_mps_st),
      .nxt_lps_o (nxt_lps_st)
   );

   // interval split and probability adaptation
   always_comb begin
      cur_st   = ctx_rd[STATE_W-1:0];
      cur_mps  = ctx_rd[CTX_BYTE_W-1];
      quart    = range_q[RANGE_W-2 -: 2];
      rng_mps  = range_q - RANGE_W'(sub_rng);
      take_lps = (off_q >= rng_mps);
      dec_bin  = take_lps ? ~cur_mps : cur_mps;
      nxt_st   = take_lps ? nxt_lps_st : nxt_mps_st;
      nxt_mps  = (take_lps && cur_st == '0) ? ~cur_mps : cur_mps;
      rng_nxt  = take_lps ? RANGE_W'(sub_rng) : rng_mps;
      off_nxt  = take_lps ? (off_q - rng_mps) : off_q;
      ctx_wb   = {nxt_mps, {PAD_W{1'b0}}, nxt_st};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_INIT;
         range_q    <= RANGE_RST;
         off_q      <= '0;
         init_cnt_q <= '0;
         idx_q      <= '0;
         rsp_valid  <= 1'b0;
         rsp_bin    <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st_q)
            ST_INIT: if (bit_valid) begin
               off_q      <= {off_q[RANGE_W-2:0], bit_data};
               init_cnt_q <= init_cnt_q + 1'b1;
               if (init_cnt_q == LAST_INIT) st_q <= ST_IDLE;
            end
            ST_IDLE: if (req_valid) begin
               idx_q <= req_ctx;
               st_q  <= ST_CALC;
            end
            ST_CALC: begin
               range_q   <= rng_nxt;
               off_q     <= off_nxt;
               rsp_valid <= 1'b1;
               rsp_bin   <= dec_bin;
               st_q      <= rng_nxt[RANGE_W-1] ? ST_IDLE : ST_RENORM;
            end
            ST_RENORM: if (bit_valid) begin
               range_q <= {range_q[RANGE_W-2:0], 1'b0};
               off_q   <= {off_q[RANGE_W-2:0], bit_data};
               if (range_q[RANGE_W-2]) st_q <= ST_IDLE;
            end
            default: st_q <= ST_INIT;
         endcase
      end
   end

   // R8
   idle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> range_q[RANGE_W-1]);
   // R5
   off_below_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE || st_q == ST_RENORM) |-> off_q < range_q);
   // R9
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R9
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ##1 rsp_valid);
   // R8
   renorm_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RENORM && bit_valid) |=> range_q == RANGE_W'($past(range_q) << 1));
   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_ready && !bit_valid) |=> $stable(off_q) && $stable(range_q));
endmodule

// File: tb/cabac_bin_decoder_bench.sv
module cabac_bin_decoder_bench;
   localparam int NBITS = 4096;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ctx_wr_en = 0, tbl_wr_en = 0, req_valid = 0, bit_valid = 0, bit_data = 0;
   logic [9:0] ctx_wr_addr = 0, req_ctx = 0;
   logic [7:0] ctx_wr_data = 0, tbl_wr_addr = 0, tbl_wr_data = 0;
   logic [1:0] tbl_wr_sel = 0;
   logic req_ready, rsp_valid, rsp_bin, bit_ready;

   always #10 clk = ~clk;

   cabac_bin_decoder u_cabac_bin_decoder (
      .clk(clk), .rst_n(rst_n),
      .ctx_wr_en(ctx_wr_en), .ctx_wr_addr(ctx_wr_addr), .ctx_wr_data(ctx_wr_data),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_sel(tbl_wr_sel), .tbl_wr_addr(tbl_wr_addr),
      .tbl_wr_data(tbl_wr_data),
      .req_valid(req_valid), .req_ready(req_ready), .req_ctx(req_ctx),
      .rsp_valid(rsp_valid), .rsp_bin(rsp_bin),
      .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data));

   int checks = 0, fails = 0;
   int unsigned seed = 32'h1d2c3b4a;
   bit bs [NBITS];
   logic [7:0] mctx [1024];
   int mrange, moff, mptr, bptr;
   bit bit_take = 0;
   int cd = 0;
   bit exp_flag = 0, exp_bin = 0, calc_live = 0;
   int calc_ctx = 0;
   string exp_tag = "";
   int collisions = 0, flips = 0, bit6_seen = 0, lps_seen = 0;
   bit done = 0;

   function automatic int unsigned xs();
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      return seed;
   endfunction

   function automatic int f_sub(int s, int q);
      return 6 + (((128 + 32 * q) * (63 - s)) >> 6);
   endfunction
   function automatic int f_nmps(int s);
      return (s < 62) ? s + 1 : 62;
   endfunction
   function automatic int f_nlps(int s);
      return s / 2;
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   endtask

   // behavioural decode of one bin, context update and bit consumption
   task automatic model_decode(int c, output bit b, output string tag);
      int s, m, q, l, ns;
      s = int'(mctx[c][5:0]); m = int'(mctx[c][7]);
      q = (mrange >> 6) & 3; l = f_sub(s, q);
      mrange = mrange - l;
      if (moff < mrange) begin
         b = bit'(m); ns = f_nmps(s); tag = "R3/R4/R6";
      end else begin
         moff = moff - mrange; mrange = l; b = bit'(!m); ns = f_nlps(s); lps_seen++;
         if (s == 0) begin m = 1 - m; tag = "R7"; flips++; end
         else tag = "R5/R6";
      end
      if (mctx[c][6]) begin tag = {tag, "/R2"}; bit6_seen++; end
      mctx[c] = {m[0], 1'b0, ns[5:0]};
      while (mrange < 256) begin
         mrange = mrange * 2;
         moff = moff * 2 + int'(bs[mptr % NBITS]);
         mptr++;
      end
   endtask

   // one clock of stimulus with per-cycle comparison against the model
   task automatic step(bit do_req, int rctx, bit do_wr, int wa, logic [7:0] wd, bit hit_calc);
      bit acc, skip, b;
      bit exp_now, exp_rdy;
      string tag;
      @(negedge clk);
      if (bit_take) bptr++;
      if (cd > 0) cd--;
      calc_live = exp_flag && cd == 1;
      exp_now = exp_flag && cd == 0;
      // R9: pulse exactly two edges after acceptance
      check(rsp_valid == exp_now, "R9 rsp_valid", int'(rsp_valid), int'(exp_now));
      if (exp_now) begin
         check(rsp_bin == exp_bin, exp_tag, int'(rsp_bin), int'(exp_bin));
         exp_flag = 0;
      end
      // R1/R8/R11: ready only once all required bits were taken
      exp_rdy = (bptr == mptr) && !exp_flag;
      check(req_ready == exp_rdy, "R1/R8/R11 req_ready", int'(req_ready), int'(exp_rdy));
      if (hit_calc && calc_live) begin do_wr = 1; wa = calc_ctx; end
      acc = do_req && req_ready;
      skip = do_wr && ((acc && wa == rctx) || (calc_live && wa == calc_ctx));
      if (skip) collisions++;
      if (acc) begin
         model_decode(rctx, b, tag);
         exp_bin = b; exp_tag = tag; exp_flag = 1; cd = 2; calc_ctx = rctx;
      end
      if (do_wr && !skip) mctx[wa] = wd;
      req_valid = do_req; req_ctx = 10'(rctx);
      ctx_wr_en = do_wr; ctx_wr_addr = 10'(wa); ctx_wr_data = wd;
      bit_valid = (xs() % 4) != 0;
      bit_data = bs[bptr % NBITS];
      bit_take = bit_valid && bit_ready;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      bs[0] = 0;
      for (int i = 1; i < NBITS; i++) bs[i] = xs() & 1;
      mrange = 510; moff = 0;
      for (int i = 0; i < 9; i++) moff = moff * 2 + int'(bs[i]);
      mptr = 9; bptr = 0;
      @(negedge clk);
      // R1 reset state
      check(req_ready == 0, "R1 req_ready in reset", int'(req_ready), 0);
      check(rsp_valid == 0, "R1 rsp_valid in reset", int'(rsp_valid), 0);
      // R3/R6 table loading; select 3 must write nothing
      tbl_wr_en = 1;
      for (int s = 0; s < 64; s++) begin
         for (int q = 0; q < 4; q++) begin
            @(negedge clk);
            tbl_wr_sel = 2'd0; tbl_wr_addr = 8'(s * 4 + q); tbl_wr_data = 8'(f_sub(s, q));
         end
         @(negedge clk); tbl_wr_sel = 2'd1; tbl_wr_addr = 8'(s); tbl_wr_data = 8'(f_nmps(s));
         @(negedge clk); tbl_wr_sel = 2'd2; tbl_wr_addr = 8'(s); tbl_wr_data = 8'(f_nlps(s));
         @(negedge clk); tbl_wr_sel = 2'd3; tbl_wr_addr = 8'(s); tbl_wr_data = 8'hff;
      end
      // context loading, some with bit 6 set (R2)
      tbl_wr_en = 0; ctx_wr_en = 1;
      for (int c = 0; c < 16; c++) begin
         @(negedge clk);
         mctx[c] = {c[0], c[1], 6'((c * 5) % 24)};
         ctx_wr_addr = 10'(c); ctx_wr_data = mctx[c];
      end
      @(negedge clk);
      ctx_wr_en = 0;
      check(rsp_valid == 0, "R1 rsp_valid still low", int'(rsp_valid), 0);
      rst_n = 1;
      for (int i = 0; i < 3000; i++) begin
         int rc;
         bit w;
         bit hc;
         int wa;
         rc = (xs() % 4 == 0) ? int'(xs() % 16) : int'(xs() % 3);
         w = 0; wa = 0; hc = (i % 7 == 3);
         if (i % 11 == 5) begin w = 1; wa = rc; end            // R10 write at acceptance
         else if (i % 13 == 2) begin w = 1; wa = int'(xs() % 16); end
         step(xs() % 4 != 0, rc, w, wa, 8'(xs() & 8'hd7), hc);
      end
      for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 8'h00, 0);
      check(bptr == mptr, "R8 bits taken", bptr, mptr);
      check(collisions > 0, "R10 collisions exercised", collisions, 1);
      check(flips > 0, "R7 MPS inversions exercised", flips, 1);
      check(bit6_seen > 0, "R2 reserved bit exercised", bit6_seen, 1);
      check(lps_seen > 0, "R5 LPS path exercised", lps_seen, 1);
      summary();
   end
endmodule